// File: doc/BRIEF.md
# Predicated Vector Immediate Left-Shift Unit

This unit decodes and executes one vector instruction: a destructive, predicated logical left shift by an immediate amount. It takes a 32-bit instruction word, a packed vector operand of `VLEN` bits and a predicate with one bit per byte of the vector. It returns the updated vector and a flag that marks an undefined encoding.

The element width (8, 16, 32 or 64 bits) and the shift distance are both taken from a single field. That field joins a 4-bit size code, split across two places in the word, with a 3-bit immediate. Each active element is shifted left. Zeros enter from the right, and bits that leave the element are lost. Each inactive element is returned as it came in.

A valid/ready handshake carries operands in and results out. Every accepted operation produces its registered result after a fixed latency of one clock.

Top module: `pred_shl_unit`

## Requirements
- R1: A size code of 0000 (code = {word[23:22], word[9:8]}) sets `undef_out` to 1 and makes `vec_out` equal to the operand vector. Every other code clears `undef_out`.
- R2: The element width follows from the highest set bit of the size code. Code 0001 gives 8 bits, 001x gives 16, 01xx gives 32 and 1xxx gives 64.
- R3: The shift distance is the unsigned value of {size code, word[7:5]} minus the element width. Its range is 0 to width−1.
- R4: An active element becomes its value shifted left by the shift distance. Zeros fill from the right, and bits shifted past the element's top are discarded.
- R5: An inactive element appears in `vec_out` unchanged.
- R6: Predicate bit e·(width/8) governs element e. The other predicate bits of that element's byte group have no effect.
- R7: A result is presented on `out_valid`/`vec_out` exactly one clock after the operand is accepted, whatever the data or predicate values. Once a result is consumed and no new operand is accepted, `out_valid` drops.
- R8: `in_ready` is low only while a result is pending and `out_ready` is low. While such a stall lasts, the result and flag hold steady.
- R9: During reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand and instruction word are offered |
| in_ready | output | 1 | Unit can take an operand this cycle |
| insn | input | 32 | Instruction word |
| vec_in | input | VLEN | Source vector, also the destination's prior value |
| pred_in | input | VLEN/8 | Governing predicate, one bit per byte |
| out_valid | output | 1 | Result is presented |
| out_ready | input | 1 | Consumer takes the result this cycle |
| vec_out | output | VLEN | Updated vector |
| undef_out | output | 1 | Reserved size code was seen |

## Verification
An operand is accepted on a rising edge where `in_valid` and `in_ready` are both high, and its vector and flag are due on the very next rising edge. The bench drives inputs on falling edges and samples one falling edge after the accepting edge, so it reads each result exactly one register stage after acceptance. For the stall case it keeps sampling on further falling edges while `out_ready` is low, and it expects the same values each time. After the stall it expects the queued operand to appear one edge after `out_ready` returns, and `out_valid` to clear one edge later.

// File: rtl/pred_shl_unit.sv
module pred_shl_unit #(
  parameter int VLEN = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       insn,
  input  logic [VLEN-1:0]   vec_in,
  input  logic [VLEN/8-1:0] pred_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VLEN-1:0]   vec_out,
  output logic              undef_out
);
  localparam int NLANE = VLEN / 8;

  logic [3:0]      code;
  logic [1:0]      sel;
  logic [6:0]      esz;
  logic [6:0]      diff;
  logic [5:0]      shamt;
  logic            bad;
  logic            take;
  logic [VLEN-1:0] nxt;

  assign code  = {insn[23:22], insn[9:8]};
  assign bad   = (code == 4'b0000);
  assign sel   = code[3] ? 2'd3 : code[2] ? 2'd2 : code[1] ? 2'd1 : 2'd0;
  assign esz   = 7'd8 << sel;
  assign diff  = {code, insn[7:5]} - esz;
  assign shamt = diff[5:0];

  wire unused_bits = &{1'b0, insn[31:24], insn[21:10], insn[4:0], diff[6]};

  for (genvar s = 0; s < 4; s++) begin : g_sz
    localparam int EW = 8 << s;
    localparam int NE = VLEN / EW;
    logic [VLEN-1:0] r;
    for (genvar e = 0; e < NE; e++) begin : g_el
      wire [EW-1:0] src = vec_in[e*EW +: EW];
      assign r[e*EW +: EW] = pred_in[e*(EW/8)] ? (src << shamt) : src;
    end
  end

  always_comb begin
    case (sel)
      2'd0:    nxt = g_sz[0].r;
      2'd1:    nxt = g_sz[1].r;
      2'd2:    nxt = g_sz[2].r;
      default: nxt = g_sz[3].r;
    endcase
    if (bad) nxt = vec_in;
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      vec_out   <= '0;
      undef_out <= 1'b0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        vec_out   <= nxt;
        undef_out <= bad;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assert_lat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(vec_out) && $stable(undef_out)));

  assert_undef_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && insn[23:22] == 2'b00 && insn[9:8] == 2'b00)
      |=> (undef_out && vec_out == $past(vec_in)));

  assert_defined_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (insn[23:22] != 2'b00 || insn[9:8] != 2'b00)) |=> !undef_out);

  always_comb begin
    if (!rst_n) assert_reset_R9: assert (in_ready && !out_valid);
  end

  wire unused_lane = &{1'b0, NLANE[0]};
endmodule

// File: tb/pred_shl_unit_bench.sv
module pred_shl_unit_bench;
  localparam int VLEN = 256;
  localparam int NL   = VLEN / 8;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            in_valid = 0;
  logic            in_ready;
  logic [31:0]     insn = '0;
  logic [VLEN-1:0] vec_in = '0;
  logic [NL-1:0]   pred_in = '0;
  logic            out_valid;
  logic            out_ready = 1;
  logic [VLEN-1:0] vec_out;
  logic            undef_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  pred_shl_unit #(.VLEN(VLEN)) u_pred_shl_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .insn(insn), .vec_in(vec_in), .pred_in(pred_in), .out_valid(out_valid),
    .out_ready(out_ready), .vec_out(vec_out), .undef_out(undef_out)
  );

  function automatic logic [31:0] mk(input logic [3:0] c, input logic [2:0] imm,
                                     input logic [2:0] pg, input logic [4:0] zd);
    return {8'b00000100, c[3:2], 9'b000011100, pg, c[1:0], imm, zd};
  endfunction

  function automatic logic [VLEN:0] model(input logic [31:0] w, input logic [VLEN-1:0] v,
                                          input logic [NL-1:0] p);
    logic [3:0] c;
    int es, sh;
    logic [VLEN-1:0] r;
    c = {w[23:22], w[9:8]};
    if (c == 4'd0) return {1'b1, v};
    es = c[3] ? 64 : c[2] ? 32 : c[1] ? 16 : 8;
    sh = int'({c, w[7:5]}) - es;
    r = v;
    for (int e = 0; e < VLEN / es; e++) begin
      if (p[e*es/8]) begin
        for (int b = 0; b < es; b++) begin
          if (b >= sh) r[e*es+b] = v[e*es+b-sh];
          else         r[e*es+b] = 1'b0;
        end
      end
    end
    return {1'b0, r};
  endfunction

  function automatic logic [VLEN-1:0] rvec();
    logic [VLEN-1:0] x;
    for (int i = 0; i < VLEN / 32; i++) x[i*32 +: 32] = $urandom;
    return x;
  endfunction

  function automatic logic [NL-1:0] rpred();
    logic [NL-1:0] x;
    for (int i = 0; i < NL; i++) x[i] = 1'($urandom);
    return x;
  endfunction

  task automatic chk(input string tag, input logic [VLEN-1:0] got, input logic [VLEN-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic xfer(input string tag, input logic [31:0] w, input logic [VLEN-1:0] v,
                      input logic [NL-1:0] p);
    logic [VLEN:0] e;
    e = model(w, v, p);
    @(negedge clk);
    insn = w; vec_in = v; pred_in = p; in_valid = 1; out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk({tag, " R7 valid"}, VLEN'(out_valid), VLEN'(1));
    chk({tag, " vec"}, vec_out, e[VLEN-1:0]);
    chk({tag, " R1 flag"}, VLEN'(undef_out), VLEN'(e[VLEN]));
  endtask

  initial begin
    #600000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [VLEN-1:0] a, b, pat;
    logic [VLEN:0] ea, eb;
    logic [31:0] w;
    int seed;
    seed = $urandom(32'd4242);
    pat = rvec();

    #1;
    chk("R9 reset valid", VLEN'(out_valid), VLEN'(0));
    chk("R9 reset ready", VLEN'(in_ready), VLEN'(1));
    repeat (3) @(negedge clk);
    rst_n = 1;

    xfer("R2 R3 b shift0 all-on", mk(4'b0001, 3'd0, 3'd1, 5'd2), pat, '1);
    xfer("R2 R3 b shift7 all-on", mk(4'b0001, 3'd7, 3'd1, 5'd2), pat, '1);
    xfer("R2 R3 h shift0", mk(4'b0010, 3'd0, 3'd0, 5'd0), pat, '1);
    xfer("R2 R3 h shift15", mk(4'b0011, 3'd7, 3'd0, 5'd0), pat, '1);
    xfer("R2 R3 s shift0", mk(4'b0100, 3'd0, 3'd0, 5'd0), pat, '1);
    xfer("R2 R3 s shift31", mk(4'b0111, 3'd7, 3'd0, 5'd0), pat, '1);
    xfer("R2 R3 d shift0", mk(4'b1000, 3'd0, 3'd0, 5'd0), pat, '1);
    xfer("R2 R3 R4 d shift63", mk(4'b1111, 3'd7, 3'd0, 5'd0), '1, '1);
    xfer("R4 d shift33", mk(4'b1100, 3'd1, 3'd0, 5'd0), pat, '1);
    xfer("R5 b all-off", mk(4'b0001, 3'd3, 3'd0, 5'd0), pat, '0);
    xfer("R5 d all-off", mk(4'b1010, 3'd5, 3'd0, 5'd0), pat, '0);
    xfer("R6 d non-governing bits only", mk(4'b1001, 3'd2, 3'd0, 5'd0), pat, {NL/8{8'hFE}});
    xfer("R6 d governing bits only", mk(4'b1001, 3'd2, 3'd0, 5'd0), pat, {NL/8{8'h01}});
    xfer("R6 h odd bits only", mk(4'b0010, 3'd4, 3'd0, 5'd0), pat, {NL/2{2'b10}});
    xfer("R1 reserved", {8'h04, 2'b00, 9'b000011100, 3'd3, 2'b00, 3'd5, 5'd7}, pat, '1);
    xfer("R1 reserved zero pred", {8'h04, 2'b00, 9'b000011100, 3'd0, 2'b00, 3'd0, 5'd0}, pat, '0);

    for (int i = 0; i < 300; i++) begin
      w = $urandom;
      if (i % 25 == 0) begin w[23:22] = 2'b00; w[9:8] = 2'b00; end
      xfer("R4 R5 random", w, rvec(), rpred());
    end

    a = rvec(); b = rvec();
    ea = model(mk(4'b0101, 3'd6, 3'd0, 5'd0), a, '1);
    eb = model(mk(4'b0001, 3'd2, 3'd0, 5'd0), b, rpred());
    @(negedge clk);
    insn = mk(4'b0101, 3'd6, 3'd0, 5'd0); vec_in = a; pred_in = '1;
    in_valid = 1; out_ready = 0;
    @(negedge clk);
    insn = mk(4'b0001, 3'd2, 3'd0, 5'd0); vec_in = b; pred_in = 'x;
    pred_in = '0;
    eb = model(insn, b, '0);
    chk("R8 stall ready low", VLEN'(in_ready), VLEN'(0));
    chk("R8 stall first result", vec_out, ea[VLEN-1:0]);
    @(negedge clk);
    chk("R8 stall held valid", VLEN'(out_valid), VLEN'(1));
    chk("R8 stall held data", vec_out, ea[VLEN-1:0]);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R8 queued op result", vec_out, eb[VLEN-1:0]);
    chk("R7 queued op valid", VLEN'(out_valid), VLEN'(1));
    @(negedge clk);
    chk("R7 drained", VLEN'(out_valid), VLEN'(0));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule